// File: doc/BRIEF.md
# Receive Mailbox Allocator with Overwrite

This block sits behind a CAN receiver that has already decoded each frame into an identifier, an extended-format flag, a remote-request flag, a length code and eight data bytes. When a frame arrives, the block picks one receive mailbox for it. A mailbox can take the frame only if it is enabled and its acceptance filter agrees with the frame. Among those, the frame goes to the lowest-numbered mailbox that is still empty. A mailbox set to overwrite mode also takes a frame when it is already full, but only if no empty mailbox accepts that frame. The new frame then replaces the old contents and a lost-message flag is set.

Software sets up each mailbox through a word-addressed register port. That setup is a mode, an acceptance mask and an identifier with an extended-format bit. Software reads back what was received. It returns mailboxes to service by writing a bit mask to a command address. Each mailbox drives its own interrupt line, which stays high while that mailbox holds an unread frame.

Register map, by word address. Address 0 is the global status word. Address 1 is the command word. Mailbox i occupies addresses 8*(i+1)+k: k=0 is the mode, k=1 the mask, k=2 the identifier, k=3 the mailbox status, k=4 the low data word and k=5 the high data word. All other addresses read as zero.

Top module: `rxmb_alloc`

## Requirements
- R1: After reset every mailbox has mode 0, mask 0, identifier 0, no data and no flags. Every interrupt line is low and the global status word reads 0.
- R2: The mode field is bits 2:0 at offset 0. Value 1 is normal receive and value 2 is receive with overwrite. Value 0 and every other value disable the mailbox, so it never captures a frame.
- R3: A frame is stored in the lowest-numbered mailbox that is enabled, accepts the frame and is not full. A full normal-mode mailbox is skipped.
- R4: A mailbox accepts a frame when two conditions hold. First, the frame identifier and the mailbox identifier (bits 28:0 at offset 2) agree in every bit that is set in the mask (bits 28:0 at offset 1). A mask of 0 accepts any identifier. Second, the frame's extended flag equals bit 29 at offset 2.
- R5: If no empty mailbox accepts a frame, the lowest full overwrite-mode mailbox that accepts it takes the frame. It replaces the whole stored frame and sets the lost flag, status bit 24.
- R6: A frame that no mailbox can take is dropped. No register or interrupt changes.
- R7: The mailbox status word holds the following fields. The length code is in bits 19:16, the remote flag in bit 20, full in bit 23 and lost in bit 24. Data bytes 3..0 read at offset 4 and bytes 7..4 at offset 5. On capture, the identifier field is set to the received identifier.
- R8: Bit i of the global status word and the line mb_irq[i] both equal the full flag of mailbox i. Each reflects a capture from the cycle after the frame is presented.
- R9: Writing the command word re-arms every mailbox whose bit is set, which clears its full and lost flags. If a frame is captured into that mailbox in the same cycle, the capture wins.
- R10: Reading never re-arms a mailbox. Writes to the global status word and to the read-only mailbox offsets (3, 4, 5) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | A decoded frame is present this cycle |
| rx_id | input | 29 | Frame identifier; a standard identifier sits in bits 28:18 |
| rx_ide | input | 1 | Frame uses the extended identifier format |
| rx_rtr | input | 1 | Frame is a remote request |
| rx_dlc | input | 4 | Frame length code |
| rx_data | input | 64 | Frame data, byte 0 in bits 7:0 |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| mb_irq | output | 8 | Per-mailbox interrupt, high while full |

## Verification
Directed cases cover the main allocation corners:
- **Full mailbox skipping:** a design that ignored occupancy would write the second frame over the first.
- **Extended-flag filter:** extended and standard frames are sent where only the extended-flag comparison decides. A design that skipped that comparison would steer extended frames into standard mailboxes instead of dropping them.
- **Overwrite ordering:** the overwrite mailbox is given a frame while empty mailboxes are still free, and again once it is the last resort. A design that preferred it too early, or failed to set the lost flag, would be caught.
- **Re-arm racing a capture:** a re-arm and a capture target the same mailbox in one cycle. A design that let the re-arm win would lose the new frame's full flag.

Seeded random traffic then mixes configuration writes, re-arms, ignored writes and frames over a small identifier pool, so filter hits and misses both occur. After every operation, every register is compared against a model held in the bench.

// File: rtl/rxmb_pkg.sv
package rxmb_pkg;
    localparam int MODE_W     = 3;
    localparam logic [MODE_W-1:0] MODE_OFF    = 3'd0;
    localparam logic [MODE_W-1:0] MODE_RX     = 3'd1;
    localparam logic [MODE_W-1:0] MODE_RX_OVR = 3'd2;

    localparam int FLD_W      = 3;
    localparam int FLD_MODE   = 0;
    localparam int FLD_MASK   = 1;
    localparam int FLD_ID     = 2;
    localparam int FLD_STAT   = 3;
    localparam int FLD_DLO    = 4;
    localparam int FLD_DHI    = 5;

    localparam int GLB_STATUS = 0;
    localparam int GLB_CMD    = 1;

    localparam int IDE_BIT    = 29;
    localparam int DLC_LSB    = 16;
    localparam int RTR_BIT    = 20;
    localparam int FULL_BIT   = 23;
    localparam int LOST_BIT   = 24;
endpackage

// File: rtl/rxmb_match.sv
module rxmb_match
    import rxmb_pkg::*;
#(
    parameter int ID_W = 29
) (
    input  logic [MODE_W-1:0] mode,
    input  logic [ID_W-1:0]   mask,
    input  logic [ID_W-1:0]   id,
    input  logic              ide,
    input  logic              full,
    input  logic [ID_W-1:0]   rx_id,
    input  logic              rx_ide,
    output logic              take_free,
    output logic              take_ovr
);
    logic hit;
    logic enabled;

    assign hit       = (((rx_id ^ id) & mask) == '0) && (rx_ide == ide);
    assign enabled   = (mode == MODE_RX) || (mode == MODE_RX_OVR);
    assign take_free = hit && enabled && !full;
    assign take_ovr  = hit && full && (mode == MODE_RX_OVR);
endmodule

// File: rtl/rxmb_pick.sv
module rxmb_pick #(
    parameter int N = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          hit,
    output logic [IW-1:0] idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/rxmb_alloc.sv
module rxmb_alloc
    import rxmb_pkg::*;
#(
    parameter int NUM_MB = 8,
    parameter int ID_W   = 29,
    parameter int DLC_W  = 4,
    parameter int REG_W  = 32,
    localparam int DATA_W = 2 * REG_W,
    localparam int ADDR_W = $clog2(8 * (NUM_MB + 1))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [ID_W-1:0]   rx_id,
    input  logic              rx_ide,
    input  logic              rx_rtr,
    input  logic [DLC_W-1:0]  rx_dlc,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic [NUM_MB-1:0] mb_irq
);
    localparam int IDX_W = (NUM_MB > 1) ? $clog2(NUM_MB) : 1;
    localparam int GRP_W = ADDR_W - FLD_W;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [ID_W-1:0]   mask;
        logic [ID_W-1:0]   id;
        logic              ide;
        logic [DLC_W-1:0]  dlc;
        logic              rtr;
        logic [DATA_W-1:0] data;
        logic              full;
        logic              lost;
    } mb_t;

    mb_t [NUM_MB-1:0] mb_q, mb_d;

    logic [NUM_MB-1:0] free_req, ovr_req, full_vec;
    logic              free_hit, ovr_hit, cap_hit, use_ovr;
    logic [IDX_W-1:0]  free_idx, ovr_idx, cap_idx, sel_idx;
    logic [GRP_W-1:0]  grp;
    logic [FLD_W-1:0]  fld;
    logic              grp_mb, cmd_wr;
    logic              unused_wdata;

    assign grp    = reg_addr[ADDR_W-1:FLD_W];
    assign fld    = reg_addr[FLD_W-1:0];
    assign grp_mb = (grp != '0) && (int'(grp) <= NUM_MB);
    assign sel_idx = IDX_W'(grp - GRP_W'(1));
    assign cmd_wr = reg_we && (grp == '0) && (fld == FLD_W'(GLB_CMD));
    assign unused_wdata = ^reg_wdata[REG_W-1:IDE_BIT+1];

    for (genvar g = 0; g < NUM_MB; g++) begin : g_mb
        rxmb_match #(.ID_W(ID_W)) u_match (
            .mode      (mb_q[g].mode),
            .mask      (mb_q[g].mask),
            .id        (mb_q[g].id),
            .ide       (mb_q[g].ide),
            .full      (mb_q[g].full),
            .rx_id     (rx_id),
            .rx_ide    (rx_ide),
            .take_free (free_req[g]),
            .take_ovr  (ovr_req[g])
        );
        assign full_vec[g] = mb_q[g].full;
    end

    rxmb_pick #(.N(NUM_MB)) u_pick_free (.req(free_req), .hit(free_hit), .idx(free_idx));
    rxmb_pick #(.N(NUM_MB)) u_pick_ovr  (.req(ovr_req),  .hit(ovr_hit),  .idx(ovr_idx));

    assign cap_hit = rx_valid && (free_hit || ovr_hit);
    assign use_ovr = !free_hit;
    assign cap_idx = free_hit ? free_idx : ovr_idx;

    always_comb begin
        mb_d = mb_q;
        for (int i = 0; i < NUM_MB; i++) begin
            if (cmd_wr && reg_wdata[i]) begin
                mb_d[i].full = 1'b0;
                mb_d[i].lost = 1'b0;
            end
        end
        if (reg_we && grp_mb) begin
            case (int'(fld))
                FLD_MODE: mb_d[sel_idx].mode = reg_wdata[MODE_W-1:0];
                FLD_MASK: mb_d[sel_idx].mask = reg_wdata[ID_W-1:0];
                FLD_ID: begin
                    mb_d[sel_idx].id  = reg_wdata[ID_W-1:0];
                    mb_d[sel_idx].ide = reg_wdata[IDE_BIT];
                end
                default: ;
            endcase
        end
        if (cap_hit) begin
            mb_d[cap_idx].id   = rx_id;
            mb_d[cap_idx].dlc  = rx_dlc;
            mb_d[cap_idx].rtr  = rx_rtr;
            mb_d[cap_idx].data = rx_data;
            mb_d[cap_idx].full = 1'b1;
            mb_d[cap_idx].lost = use_ovr | mb_d[cap_idx].lost;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mb_q <= '0;
        else        mb_q <= mb_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (grp == '0) begin
            if (fld == FLD_W'(GLB_STATUS)) reg_rdata[NUM_MB-1:0] = full_vec;
        end else if (grp_mb) begin
            case (int'(fld))
                FLD_MODE: reg_rdata[MODE_W-1:0] = mb_q[sel_idx].mode;
                FLD_MASK: reg_rdata[ID_W-1:0]   = mb_q[sel_idx].mask;
                FLD_ID: begin
                    reg_rdata[ID_W-1:0] = mb_q[sel_idx].id;
                    reg_rdata[IDE_BIT]  = mb_q[sel_idx].ide;
                end
                FLD_STAT: begin
                    reg_rdata[DLC_LSB +: DLC_W] = mb_q[sel_idx].dlc;
                    reg_rdata[RTR_BIT]          = mb_q[sel_idx].rtr;
                    reg_rdata[FULL_BIT]         = mb_q[sel_idx].full;
                    reg_rdata[LOST_BIT]         = mb_q[sel_idx].lost;
                end
                FLD_DLO: reg_rdata = mb_q[sel_idx].data[REG_W-1:0];
                FLD_DHI: reg_rdata = mb_q[sel_idx].data[DATA_W-1:REG_W];
                default: ;
            endcase
        end
    end

    assign mb_irq = full_vec;
endmodule

// File: rtl/rxmb_chk.sv
module rxmb_chk
    import rxmb_pkg::*;
#(
    parameter int NUM_MB = 8,
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_valid,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [NUM_MB-1:0] cmd_bits,
    input logic [NUM_MB-1:0] stat_bits,
    input logic [NUM_MB-1:0] mb_irq
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> mb_irq == '0);

    // R8
    status_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(GLB_STATUS)) |-> stat_bits == mb_irq);

    // R3
    single_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mb_irq & ~$past(mb_irq)) <= 1);

    // R6
    fill_needs_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(mb_irq & ~$past(mb_irq))) |-> $past(rx_valid));

    // R9
    rearm_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_we && reg_addr == ADDR_W'(GLB_CMD) && !rx_valid)
        |-> (mb_irq & $past(cmd_bits)) == '0);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rx_valid) && !$past(reg_we)) |-> $stable(mb_irq));
endmodule

bind rxmb_alloc rxmb_chk #(.NUM_MB(NUM_MB), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .cmd_bits  (reg_wdata[NUM_MB-1:0]),
    .stat_bits (reg_rdata[NUM_MB-1:0]),
    .mb_irq    (mb_irq)
);

// File: tb/tb_rxmb_alloc.sv
`timescale 1ns/1ps
module tb_rxmb_alloc;
    localparam int NUM_MB = 8;
    localparam int ADDR_W = $clog2(8 * (NUM_MB + 1));

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rx_valid = 1'b0;
    logic [28:0]       rx_id = '0;
    logic              rx_ide = 1'b0;
    logic              rx_rtr = 1'b0;
    logic [3:0]        rx_dlc = '0;
    logic [63:0]       rx_data = '0;
    logic              reg_we = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic [NUM_MB-1:0] mb_irq;

    rxmb_alloc #(.NUM_MB(NUM_MB)) dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_id(rx_id),
        .rx_ide(rx_ide), .rx_rtr(rx_rtr), .rx_dlc(rx_dlc), .rx_data(rx_data),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .mb_irq(mb_irq)
    );

    always #2 clk = ~clk;

    logic [2:0]  m_mode [NUM_MB];
    logic [28:0] m_mask [NUM_MB];
    logic [28:0] m_id   [NUM_MB];
    logic        m_ide  [NUM_MB];
    logic        m_full [NUM_MB];
    logic        m_lost [NUM_MB];
    logic        m_rtr  [NUM_MB];
    logic [3:0]  m_dlc  [NUM_MB];
    logic [63:0] m_data [NUM_MB];

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] m_status();
        logic [7:0] v;
        for (int i = 0; i < NUM_MB; i++) v[i] = m_full[i];
        return v;
    endfunction

    function automatic logic [31:0] exp_rd(int a);
        int g = a / 8;
        int f = a % 8;
        logic [31:0] v = '0;
        if (g == 0) begin
            if (f == 0) v[NUM_MB-1:0] = m_status();
        end else if (g <= NUM_MB) begin
            int i = g - 1;
            case (f)
                0: v[2:0]  = m_mode[i];
                1: v[28:0] = m_mask[i];
                2: begin v[28:0] = m_id[i]; v[29] = m_ide[i]; end
                3: begin
                    v[19:16] = m_dlc[i]; v[20] = m_rtr[i];
                    v[23] = m_full[i];   v[24] = m_lost[i];
                end
                4: v = m_data[i][31:0];
                5: v = m_data[i][63:32];
                default: v = '0;
            endcase
        end
        return v;
    endfunction

    function automatic int mb_addr(int i, int f);
        return 8 * (i + 1) + f;
    endfunction

    task automatic rd(int a, output logic [31:0] v);
        reg_addr = ADDR_W'(a);
        #0.2;
        v = reg_rdata;
    endtask

    task automatic cmp_reg(string req, int a);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp_rd(a));
    endtask

    task automatic cmp_all(string req);
        chk(req, 32'(mb_irq), 32'(m_status()));
        for (int a = 0; a < 8 * (NUM_MB + 1); a++) cmp_reg(req, a);
    endtask

    function automatic bit accepts(int i, logic [28:0] id, logic ide);
        return (((id ^ m_id[i]) & m_mask[i]) == '0) && (ide == m_ide[i]);
    endfunction

    function automatic int find_slot(logic [28:0] id, logic ide, output bit ovr);
        ovr = 1'b0;
        for (int i = 0; i < NUM_MB; i++)
            if ((m_mode[i] == 3'd1 || m_mode[i] == 3'd2) && !m_full[i] && accepts(i, id, ide))
                return i;
        for (int i = 0; i < NUM_MB; i++)
            if (m_mode[i] == 3'd2 && m_full[i] && accepts(i, id, ide)) begin
                ovr = 1'b1;
                return i;
            end
        return -1;
    endfunction

    task automatic model_wr(int a, logic [31:0] d);
        int g = a / 8;
        int f = a % 8;
        if (g == 0 && f == 1) begin
            for (int i = 0; i < NUM_MB; i++)
                if (d[i]) begin m_full[i] = 1'b0; m_lost[i] = 1'b0; end
        end else if (g >= 1 && g <= NUM_MB) begin
            case (f)
                0: m_mode[g-1] = d[2:0];
                1: m_mask[g-1] = d[28:0];
                2: begin m_id[g-1] = d[28:0]; m_ide[g-1] = d[29]; end
                default: ;
            endcase
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        reg_we = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
        model_wr(a, d);
    endtask

    task automatic send(logic [28:0] id, logic ide, logic rtr, logic [3:0] dlc,
                        logic [63:0] data, bit with_cmd, logic [NUM_MB-1:0] cmd);
        bit ovr;
        int s = find_slot(id, ide, ovr);
        rx_valid = 1'b1; rx_id = id; rx_ide = ide; rx_rtr = rtr;
        rx_dlc = dlc; rx_data = data;
        if (with_cmd) begin
            reg_we = 1'b1; reg_addr = ADDR_W'(1); reg_wdata = 32'(cmd);
        end
        @(posedge clk); #1;
        rx_valid = 1'b0; reg_we = 1'b0;
        if (with_cmd) model_wr(1, 32'(cmd));
        if (s >= 0) begin
            m_id[s] = id; m_dlc[s] = dlc; m_rtr[s] = rtr; m_data[s] = data;
            m_full[s] = 1'b1;
            if (ovr) m_lost[s] = 1'b1;
        end
    endtask

    task automatic sendf(logic [28:0] id, logic ide, logic [3:0] dlc, logic [63:0] data);
        send(id, ide, 1'b0, dlc, data, 1'b0, '0);
    endtask

    function automatic logic [28:0] pick_id();
        case ($urandom_range(0, 3))
            0: return 29'h0;
            1: return 29'h0ABC_DEF;
            2: return {11'h123, 18'h0};
            default: return 29'($urandom);
        endcase
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd7741));
        for (int i = 0; i < NUM_MB; i++) begin
            m_mode[i] = '0; m_mask[i] = '0; m_id[i] = '0; m_ide[i] = 1'b0;
            m_full[i] = 1'b0; m_lost[i] = 1'b0; m_rtr[i] = 1'b0;
            m_dlc[i] = '0; m_data[i] = '0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R1 reset state
        chk("R1 irq", 32'(mb_irq), 32'h0);
        cmp_all("R1");

        // R2 / R6 all mailboxes disabled: frame dropped
        sendf(29'h0, 1'b0, 4'd8, 64'h1111_2222_3333_4444);
        rd(0, v); chk("R6 drop when disabled", v, 32'h0);
        cmp_all("R2");

        for (int i = 0; i < 4; i++) wr(mb_addr(i, 0), 32'd1);
        wr(mb_addr(7, 0), 32'd2);
        wr(mb_addr(4, 0), 32'd1);
        wr(mb_addr(4, 1), 32'h1FFF_FFFF);
        wr(mb_addr(4, 2), 32'h2000_0000 | 32'h0ABC_DEF);
        wr(mb_addr(5, 0), 32'd5);
        cmp_all("R2 config");

        // R3 lowest free mailbox
        sendf({11'h555, 18'h0}, 1'b0, 4'd3, 64'hDEAD_BEEF_0BAD_F00D);
        rd(0, v); chk("R3 first to mb0", v, 32'h01);
        rd(mb_addr(0, 4), v); chk("R7 data low", v, 32'h0BAD_F00D);
        rd(mb_addr(0, 5), v); chk("R7 data high", v, 32'hDEAD_BEEF);
        rd(mb_addr(0, 3), v); chk("R7 status", v, 32'h0083_0000);
        rd(mb_addr(0, 2), v); chk("R7 id", v, 32'(29'({11'h555, 18'h0})));
        sendf({11'h556, 18'h0}, 1'b0, 4'd2, 64'h5);
        rd(0, v); chk("R3 full skipped", v, 32'h03);
        chk("R8 irq", 32'(mb_irq), 32'h03);

        // R10 reads and ignored writes
        rd(mb_addr(0, 4), v); rd(mb_addr(0, 3), v);
        rd(0, v); chk("R10 read no rearm", v, 32'h03);
        wr(0, 32'h0);
        wr(mb_addr(0, 3), 32'hFFFF_FFFF);
        wr(mb_addr(0, 4), 32'h1234_5678);
        rd(0, v); chk("R10 status write ignored", v, 32'h03);
        cmp_all("R10");

        // R4 extended flag and mask
        sendf(29'h0ABC_DEF, 1'b1, 4'd1, 64'h77);
        rd(0, v); chk("R4 ext to mb4", v, 32'h13);
        sendf(29'h0ABC_DEE, 1'b1, 4'd1, 64'h78);
        rd(0, v); chk("R6 ext mismatch dropped", v, 32'h13);
        cmp_all("R4");

        // R5 overwrite
        sendf(29'h1, 1'b0, 4'd4, 64'hC);
        sendf(29'h2, 1'b0, 4'd4, 64'hD);
        rd(0, v); chk("R3 fill mb2 mb3", v, 32'h1F);
        sendf(29'h3, 1'b0, 4'd5, 64'hE);
        rd(0, v); chk("R5 overwrite box used when free", v, 32'h9F);
        rd(mb_addr(7, 3), v); chk("R5 no lost yet", v, 32'h0085_0000);
        send(29'h4, 1'b0, 1'b1, 4'd6, 64'hF0F0, 1'b0, '0);
        rd(mb_addr(7, 3), v); chk("R5 lost set", v, 32'h0196_0000);
        rd(mb_addr(7, 4), v); chk("R5 replaced data", v, 32'h0000_F0F0);
        cmp_all("R5");

        // R9 rearm
        wr(1, 32'h81);
        rd(0, v); chk("R9 rearm", v, 32'h1E);
        rd(mb_addr(7, 3), v); chk("R9 lost cleared", v, 32'h0016_0000);
        send(29'h9, 1'b0, 1'b0, 4'd7, 64'h99, 1'b1, 8'h01);
        rd(0, v); chk("R9 capture wins", v, 32'h1F);
        cmp_all("R9");

        // random mix
        for (int n = 0; n < 300; n++) begin
            int op = $urandom_range(0, 9);
            if (op <= 1) begin
                int i = $urandom_range(0, NUM_MB - 1);
                int f = $urandom_range(0, 2);
                logic [31:0] d;
                case (f)
                    0: d = 32'($urandom_range(0, 3));
                    1: d = ($urandom_range(0, 1) == 0) ? 32'h0 : 32'h1FFF_FFFF;
                    default: d = {2'b0, 1'($urandom_range(0, 1)), pick_id()};
                endcase
                wr(mb_addr(i, f), d);
                cmp_all("R4 random config");
            end else if (op == 2) begin
                wr(1, 32'($urandom_range(0, 255)));
                cmp_all("R9 random rearm");
            end else if (op == 3) begin
                int i = $urandom_range(0, NUM_MB - 1);
                wr(($urandom_range(0, 1) == 0) ? 0 : mb_addr(i, $urandom_range(3, 5)), $urandom);
                cmp_all("R10 random ignored write");
            end else begin
                send(pick_id(), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                     4'($urandom_range(0, 15)), {$urandom, $urandom}, 1'b0, '0);
                cmp_all("R3 R5 random frame");
            end
        end

        summary();
        $finish;
    end
endmodule